// File: doc/BRIEF.md
# Fetch Translation Shortcut

This block is a one-entry memory of the most recent instruction-fetch translation, and it sits in front of the full instruction TLB lookup. For each translation it stores the complete translation-state word that was in force: the privilege bits, the partition and the context. It also stores what that translation produced. That result is one of two things: a TLB entry (index, virtual range, physical base and page-offset mask), or a bypass marker meaning "no translation, physical equals virtual masked to the implemented physical width".

Each fetch request is compared against the stored item. On a hit, the physical address is returned one cycle later without a full lookup. On a miss, the fetch goes to the slow path, and the response says whether the fetch address was misaligned. When the slow path finishes, it writes its result back through the fill port. A flush input empties the shortcut, for example when TLB contents change.

Top module: `fetch_xlate_shortcut`

## Requirements
- R1: After reset, `resp_valid` is low and the shortcut is empty, so the first request misses.
- R2: A hit requires a stored item and a stored state word equal in every bit to `req_state`. A difference in any one bit gives a miss.
- R3: When the stored item is the bypass marker, a hit returns `resp_bypass`=1 and `resp_pa` = `req_va` AND `PA_IMPL_MASK`.
- R4: When the stored item is an entry, a hit also requires two conditions. The entry's range start must be below `req_va`+4, with the 4 bytes being the fetch size. The range start plus the range length must be at or above `req_va`. Both comparisons use unsigned values one bit wider than the address.
- R5: An entry hit returns `resp_pa` = (stored physical base AND NOT offset mask) OR (`req_va` AND offset mask), and returns `resp_idx` = the stored entry index.
- R6: On a miss, `resp_misalign` is 1 exactly when `req_va[1:0]` is not zero. On a hit, `resp_misalign` is 0, and a miss also returns `resp_pa`=0.
- R7: A fill stores the fill state word, and it stores the bypass marker if `fill_bypass` is set or if bit 0 or bit 1 of `fill_state` is set. Otherwise it stores the entry fields.
- R8: `flush` empties the shortcut. When a fill and a flush arrive in the same cycle, the flush wins.
- R9: A fill or flush affects requests from the next cycle on. A request in the same cycle sees the old contents.
- R10: `resp_valid` rises exactly one cycle after `req_valid` and is low otherwise. While it is low, `resp_hit` and `resp_misalign` are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch translation request |
| req_va | input | ADDR_W | Fetch virtual address |
| req_state | input | STATE_W | Current translation-state word |
| fill_valid | input | 1 | Write a slow-path result |
| fill_bypass | input | 1 | Result is the bypass marker |
| fill_state | input | STATE_W | State word the result was made under |
| fill_idx | input | IDX_W | Matched TLB entry index |
| fill_base | input | ADDR_W | Entry virtual range start |
| fill_len | input | ADDR_W | Entry virtual range length |
| fill_pa | input | ADDR_W | Entry physical base |
| fill_offmask | input | ADDR_W | Entry page-offset mask (ones in offset bits) |
| flush | input | 1 | Empty the shortcut |
| resp_valid | output | 1 | Response to last cycle's request |
| resp_hit | output | 1 | Shortcut hit |
| resp_bypass | output | 1 | Hit was on the bypass marker |
| resp_idx | output | IDX_W | Entry index on an entry hit |
| resp_pa | output | ADDR_W | Physical address on a hit |
| resp_misalign | output | 1 | Miss with misaligned fetch address |

## Verification
Every response is due exactly one clock edge after its request. The bench therefore drives a request on a falling edge and samples all response outputs just after the next rising edge. A fill or flush is given one edge before the request that must observe it, and the same-cycle cases present both on one edge and then check the request's response against the old contents. Range boundaries are probed at the start minus 3 and minus 4, and at the end and the end plus 1.

// File: rtl/fetch_xlate_shortcut.sv
module fetch_xlate_shortcut #(
  parameter int ADDR_W = 44,
  parameter int STATE_W = 64,
  parameter int IDX_W = 6,
  parameter logic [ADDR_W-1:0] PA_IMPL_MASK = 44'h0FF_FFFF_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_va,
  input  logic [STATE_W-1:0] req_state,
  input  logic               fill_valid,
  input  logic               fill_bypass,
  input  logic [STATE_W-1:0] fill_state,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [ADDR_W-1:0]  fill_base,
  input  logic [ADDR_W-1:0]  fill_len,
  input  logic [ADDR_W-1:0]  fill_pa,
  input  logic [ADDR_W-1:0]  fill_offmask,
  input  logic               flush,
  output logic               resp_valid,
  output logic               resp_hit,
  output logic               resp_bypass,
  output logic [IDX_W-1:0]   resp_idx,
  output logic [ADDR_W-1:0]  resp_pa,
  output logic               resp_misalign
);
  localparam int XW = ADDR_W + 1;
  localparam logic [XW-1:0] FETCH_BYTES = XW'(4);

  logic               vld_q, byp_q;
  logic [STATE_W-1:0] st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [ADDR_W-1:0]  base_q, len_q, pa_q, msk_q;

  logic [XW-1:0] va_x, lo_x, hi_x;
  logic          state_eq, in_range, hit;
  logic [ADDR_W-1:0] hit_pa;

  assign va_x     = {1'b0, req_va};
  assign lo_x     = {1'b0, base_q};
  assign hi_x     = {1'b0, base_q} + {1'b0, len_q};
  assign state_eq = (st_q == req_state);
  assign in_range = (lo_x < va_x + FETCH_BYTES) && (hi_x >= va_x);
  assign hit      = vld_q && state_eq && (byp_q || in_range);
  assign hit_pa   = byp_q ? (req_va & PA_IMPL_MASK)
                          : ((pa_q & ~msk_q) | (req_va & msk_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      byp_q  <= 1'b0;
      st_q   <= '0;
      idx_q  <= '0;
      base_q <= '0;
      len_q  <= '0;
      pa_q   <= '0;
      msk_q  <= '0;
    end else if (flush) begin
      vld_q <= 1'b0;
    end else if (fill_valid) begin
      vld_q  <= 1'b1;
      byp_q  <= fill_bypass || (|fill_state[1:0]);
      st_q   <= fill_state;
      idx_q  <= fill_idx;
      base_q <= fill_base;
      len_q  <= fill_len;
      pa_q   <= fill_pa;
      msk_q  <= fill_offmask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid    <= 1'b0;
      resp_hit      <= 1'b0;
      resp_bypass   <= 1'b0;
      resp_idx      <= '0;
      resp_pa       <= '0;
      resp_misalign <= 1'b0;
    end else begin
      resp_valid    <= req_valid;
      resp_hit      <= req_valid && hit;
      resp_bypass   <= req_valid && hit && byp_q;
      resp_idx      <= (req_valid && hit && !byp_q) ? idx_q : '0;
      resp_pa       <= (req_valid && hit) ? hit_pa : '0;
      resp_misalign <= req_valid && !hit && (req_va[1:0] != 2'b00);
    end
  end

  a_r10_resp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !resp_hit && !resp_misalign);
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld_q);
  a_r7_priv_fill_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && (fill_state[1:0] != 2'b00)) |=> vld_q && byp_q);
  a_r2_state_mismatch_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_state != st_q)) |=> !resp_hit);
  a_r3_bypass_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_bypass) |-> resp_pa == ($past(req_va) & PA_IMPL_MASK));
  a_r6_hit_aligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> !resp_misalign);
endmodule

// File: tb/test_fetch_xlate_shortcut.sv
module test_fetch_xlate_shortcut;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 44;
  localparam int SW = 64;
  localparam int IW = 6;
  localparam logic [AW-1:0] IMPL = 44'h0FF_FFFF_FFFF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, fill_valid = 0, fill_bypass = 0, flush = 0;
  logic [AW-1:0] req_va = '0, fill_base = '0, fill_len = '0, fill_pa = '0, fill_offmask = '0;
  logic [SW-1:0] req_state = '0, fill_state = '0;
  logic [IW-1:0] fill_idx = '0;
  logic resp_valid, resp_hit, resp_bypass, resp_misalign;
  logic [IW-1:0] resp_idx;
  logic [AW-1:0] resp_pa;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_xlate_shortcut #(.ADDR_W(AW), .STATE_W(SW), .IDX_W(IW), .PA_IMPL_MASK(IMPL)) i_fetch_xlate_shortcut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_state(req_state),
    .fill_valid(fill_valid), .fill_bypass(fill_bypass), .fill_state(fill_state), .fill_idx(fill_idx),
    .fill_base(fill_base), .fill_len(fill_len), .fill_pa(fill_pa), .fill_offmask(fill_offmask),
    .flush(flush), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_bypass(resp_bypass),
    .resp_idx(resp_idx), .resp_pa(resp_pa), .resp_misalign(resp_misalign));

  localparam logic [SW-1:0] S_HYP  = 64'h0000_1234_0000_0501;
  localparam logic [SW-1:0] S_NORM = 64'h0000_0077_0000_0304;
  localparam logic [AW-1:0] BASE = 44'h0_0001_0000;
  localparam logic [AW-1:0] LEN  = 44'h0_0000_2000;
  localparam logic [AW-1:0] PBAS = 44'h7_5000_0000;
  localparam logic [AW-1:0] OMSK = 44'h0_0000_1FFF;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(logic byp, logic [SW-1:0] st, logic [IW-1:0] idx, logic [AW-1:0] b,
                         logic [AW-1:0] l, logic [AW-1:0] p, logic [AW-1:0] m, logic fl);
    @(negedge clk);
    fill_valid = 1; fill_bypass = byp; fill_state = st; fill_idx = idx;
    fill_base = b; fill_len = l; fill_pa = p; fill_offmask = m; flush = fl;
    @(negedge clk);
    fill_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic lookup(string req, logic [AW-1:0] va, logic [SW-1:0] st,
                        logic eh, logic eb, logic [IW-1:0] ei, logic [AW-1:0] ep, logic em);
    @(negedge clk);
    req_valid = 1; req_va = va; req_state = st;
    @(posedge clk); #1;
    chk(req, "valid", 64'(resp_valid), 64'(1'b1));
    chk(req, "hit", 64'(resp_hit), 64'(eh));
    chk(req, "bypass", 64'(resp_bypass), 64'(eb));
    chk(req, "idx", 64'(resp_idx), 64'(ei));
    chk(req, "pa", 64'(resp_pa), 64'(ep));
    chk(req, "misalign", 64'(resp_misalign), 64'(em));
    @(negedge clk); req_valid = 0;
  endtask

  function automatic logic [AW-1:0] entry_pa(logic [AW-1:0] va);
    return (PBAS & ~OMSK) | (va & OMSK);
  endfunction

  task automatic t_reset();
    #1; chk("R1", "resp_valid in reset", 64'(resp_valid), 0);
    lookup("R1", 44'h0_0000_1002, S_NORM, 0, 0, 0, 0, 1);
    @(negedge clk); #1;
    chk("R10", "valid drops without request", 64'(resp_valid), 0);
  endtask

  task automatic t_bypass();
    do_fill(0, S_HYP, 6'd9, BASE, LEN, PBAS, OMSK, 0);
    lookup("R7 R3", 44'hABC_DEF0_1236, S_HYP, 1, 1, 0, 44'hABC_DEF0_1236 & IMPL, 0);
    lookup("R2", 44'hABC_DEF0_1236, S_HYP ^ 64'h0000_0100_0000_0000, 0, 0, 0, 0, 1);
    do_fill(1, S_NORM, 6'd9, BASE, LEN, PBAS, OMSK, 0);
    lookup("R7 R3 flag", 44'hF00_0000_0040, S_NORM, 1, 1, 0, 44'hF00_0000_0040 & IMPL, 0);
  endtask

  task automatic t_entry();
    do_fill(0, S_NORM, 6'd5, BASE, LEN, PBAS, OMSK, 0);
    lookup("R5", BASE + 44'h124, S_NORM, 1, 0, 5, entry_pa(BASE + 44'h124), 0);
    lookup("R4 start-3", BASE - 44'd3, S_NORM, 1, 0, 5, entry_pa(BASE - 44'd3), 0);
    lookup("R4 start-4", BASE - 44'd4, S_NORM, 0, 0, 0, 0, 0);
    lookup("R4 end", BASE + LEN, S_NORM, 1, 0, 5, entry_pa(BASE + LEN), 0);
    lookup("R4 end+1 R6", BASE + LEN + 44'd1, S_NORM, 0, 0, 0, 0, 1);
    lookup("R2 one bit", BASE + 44'h124, S_NORM ^ 64'h1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_flush();
    do_flush();
    lookup("R8 flush", BASE + 44'h124, S_NORM, 0, 0, 0, 0, 0);
    do_fill(0, S_NORM, 6'd5, BASE, LEN, PBAS, OMSK, 1);
    lookup("R8 flush wins", BASE + 44'h124, S_NORM, 0, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    req_valid = 1; req_va = BASE + 44'h8; req_state = S_NORM;
    fill_valid = 1; fill_bypass = 0; fill_state = S_NORM; fill_idx = 6'd12;
    fill_base = BASE; fill_len = LEN; fill_pa = PBAS; fill_offmask = OMSK;
    @(posedge clk); #1;
    chk("R9", "hit with same-cycle fill", 64'(resp_hit), 0);
    @(negedge clk); fill_valid = 0; req_valid = 0;
    lookup("R9 after fill", BASE + 44'h8, S_NORM, 1, 0, 12, entry_pa(BASE + 44'h8), 0);
    @(negedge clk);
    req_valid = 1; flush = 1;
    @(posedge clk); #1;
    chk("R9", "hit with same-cycle flush", 64'(resp_hit), 1);
    @(negedge clk); flush = 0; req_valid = 0;
    lookup("R9 after flush", BASE + 44'h8, S_NORM, 0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic t_reset_wrap();
    repeat (3) @(posedge clk);
    t_reset_pre();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_bypass();
    t_entry();
    t_flush();
    t_same_cycle();
  endtask

  task automatic t_reset_pre();
    #1; chk("R1", "resp_hit in reset", 64'(resp_hit), 0);
  endtask
endmodule